// File: doc/BRIEF.md
# Accumulator and Extend-Bit Unit

This block holds a 16-bit working accumulator and a single extend bit, together with the arithmetic and logic stage that computes their next values. On each clock edge it can combine the accumulator with a 16-bit data operand by AND or by addition, or load it from that operand. It can also place an 8-bit input byte into the low half of the accumulator. Any carry out of an addition is kept in the extend bit.

A second command path carries register-reference commands, one bit per command. These commands clear or invert the accumulator and the extend bit, rotate the 17-bit ring made of the accumulator and the extend bit in either direction, or increment the accumulator. The same command word selects up to four skip tests. These tests look at the sign bit, at an all-zero accumulator and at a cleared extend bit, and the result is raised as a combinational skip request for the sequencer around the block. Zero and sign flags are decoded from the registered accumulator.

Top module: `acc_unit`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator reads 0x0000, the extend bit reads 0, acc_zero reads 1 and acc_sign reads 0.
- R2: When op_and is set, the accumulator takes the bitwise AND of itself and dr_in at the next edge, and the extend bit keeps its value.
- R3: When op_add is set, the accumulator takes the low 16 bits of accumulator plus dr_in, and the extend bit takes the carry out of bit 15.
- R4: When op_load is set, the accumulator takes dr_in. When op_inbyte is set, only accumulator bits 7:0 take in_byte and bits 15:8 keep their value. Neither operation changes the extend bit.
- R5: Command bit 11 (code 0x7800) clears the accumulator, and command bit 10 (code 0x7400) clears the extend bit.
- R6: Command bit 9 (code 0x7200) inverts every accumulator bit, and command bit 8 (code 0x7100) inverts the extend bit.
- R7: Command bit 7 (code 0x7080) rotates right through the extend bit. Accumulator bit 15 takes the old extend bit, the extend bit takes old bit 0, and bit i takes old bit i+1.
- R8: Command bit 6 (code 0x7040) rotates left through the extend bit. Accumulator bit 0 takes the old extend bit, the extend bit takes old bit 15, and bit i takes old bit i-1.
- R9: Command bit 5 (code 0x7020) adds one to the accumulator, modulo 2^16, and leaves the extend bit unchanged.
- R10: skip_req is the OR of the selected tests on the current registered state: bit 4 (0x7010) tests for sign bit 0, bit 3 (0x7008) for sign bit 1, bit 2 (0x7004) for an accumulator of zero, and bit 1 (0x7002) for an extend bit of zero. It is 0 when rr_en is low or a data operation strobe is set. Skip tests alone change no state.
- R11: When several command bits are set together, they apply in this order: the clears, then the inversions, then the right rotation, then the left rotation, then the increment.
- R12: The data operation strobes take priority over the command path. With no strobe and rr_en low, the state holds.
- R13: acc_zero and acc_sign follow the registered accumulator in the same cycle that it changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_and | input | 1 | AND accumulator with dr_in |
| op_add | input | 1 | Add dr_in, carry into extend bit |
| op_load | input | 1 | Load accumulator from dr_in |
| op_inbyte | input | 1 | Load accumulator low byte from in_byte |
| rr_en | input | 1 | Register-reference command valid |
| rr_bits | input | 11 | Command bits 11:1 of the command word |
| dr_in | input | 16 | Data operand |
| in_byte | input | 8 | Input byte |
| acc_q | output | 16 | Registered accumulator |
| e_q | output | 1 | Registered extend bit |
| acc_zero | output | 1 | Accumulator is all zero |
| acc_sign | output | 1 | Accumulator bit 15 |
| skip_req | output | 1 | Skip request from selected tests |

## Verification
The addition is driven with operands that overflow, operands that do not, and two sign-bit operands that carry with a zero sum. These cases separate a carry that is dropped from a carry that lands in the extend bit. The rotations start from patterns with both end bits set and the extend bit at either value, so a plain shift gives a different result from a 17-bit ring, and a wrong direction is also caught. Combined command words are chosen so that each ordering of clear, invert, rotate and increment gives a different result. Skip tests are run with the accumulator negative, zero and positive and with the extend bit at both values. A skip test with rr_en low confirms that the request stays clear.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
    parameter int unsigned ACC_W  = 16;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned RR_W   = 12;

    localparam int unsigned RR_CLR_AC = 11;
    localparam int unsigned RR_CLR_E  = 10;
    localparam int unsigned RR_CMP_AC = 9;
    localparam int unsigned RR_CMP_E  = 8;
    localparam int unsigned RR_ROR    = 7;
    localparam int unsigned RR_ROL    = 6;
    localparam int unsigned RR_INC    = 5;
    localparam int unsigned RR_SK_POS = 4;
    localparam int unsigned RR_SK_NEG = 3;
    localparam int unsigned RR_SK_ZER = 2;
    localparam int unsigned RR_SK_EZ  = 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             e;
    } acc_state_t;

    typedef enum logic [2:0] {
        MOP_NONE,
        MOP_AND,
        MOP_ADD,
        MOP_LOAD,
        MOP_INBYTE
    } mem_op_e;

    typedef struct packed {
        logic clr_ac;
        logic clr_e;
        logic cmp_ac;
        logic cmp_e;
        logic ror;
        logic rol;
        logic inc;
    } rr_cmd_t;

    typedef struct packed {
        logic pos;
        logic neg;
        logic zer;
        logic ez;
    } skip_sel_t;
endpackage

// File: rtl/acc_memop.sv
`timescale 1ns/1ps
module acc_memop
    import acc_pkg::*;
(
    input  mem_op_e          op,
    input  acc_state_t       cur,
    input  logic [ACC_W-1:0] dr,
    input  logic [BYTE_W-1:0] byte_in,
    output acc_state_t       nxt
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, cur.acc} + {1'b0, dr};
        nxt = cur;
        unique case (op)
            MOP_AND:    nxt.acc = cur.acc & dr;
            MOP_ADD:    nxt     = {sum[ACC_W-1:0], sum[ACC_W]};
            MOP_LOAD:   nxt.acc = dr;
            MOP_INBYTE: nxt.acc[BYTE_W-1:0] = byte_in;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/acc_rrchain.sv
`timescale 1ns/1ps
module acc_rrchain
    import acc_pkg::*;
(
    input  rr_cmd_t    cmd,
    input  acc_state_t cur,
    output acc_state_t nxt
);
    localparam int unsigned N_STAGE = 5;

    acc_state_t st [N_STAGE+1];

    assign st[0] = cur;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        always_comb begin
            st[g+1] = st[g];
            case (g)
                0: begin
                    if (cmd.clr_ac) st[g+1].acc = '0;
                    if (cmd.clr_e)  st[g+1].e   = 1'b0;
                end
                1: begin
                    if (cmd.cmp_ac) st[g+1].acc = ~st[g].acc;
                    if (cmd.cmp_e)  st[g+1].e   = ~st[g].e;
                end
                2: if (cmd.ror)
                    st[g+1] = {st[g].e, st[g].acc[ACC_W-1:1], st[g].acc[0]};
                3: if (cmd.rol)
                    st[g+1] = {st[g].acc[ACC_W-2:0], st[g].e, st[g].acc[ACC_W-1]};
                default: if (cmd.inc) st[g+1].acc = st[g].acc + 1'b1;
            endcase
        end
    end

    assign nxt = st[N_STAGE];
endmodule

// File: rtl/acc_skip.sv
`timescale 1ns/1ps
module acc_skip
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  skip_sel_t        sel,
    input  logic [ACC_W-1:0] acc,
    input  logic             e,
    output logic             skip
);
    logic hit_pos, hit_neg, hit_zer, hit_ez;

    always_comb begin
        hit_pos = sel.pos & ~acc[ACC_W-1];
        hit_neg = sel.neg &  acc[ACC_W-1];
        hit_zer = sel.zer & (acc == '0);
        hit_ez  = sel.ez  & ~e;
        skip    = active & (hit_pos | hit_neg | hit_zer | hit_ez);
    end

    // R10: an idle command path never requests a skip
    a_r10_idle_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !skip);
    // R10: a request for a clear extend bit skips exactly when it is clear
    a_r10_ez_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sel == 4'b0001) |-> (skip == !e));
endmodule

// File: rtl/acc_unit.sv
`timescale 1ns/1ps
module acc_unit
    import acc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_and,
    input  logic                op_add,
    input  logic                op_load,
    input  logic                op_inbyte,
    input  logic                rr_en,
    input  logic [RR_W-1:1]     rr_bits,
    input  logic [ACC_W-1:0]    dr_in,
    input  logic [BYTE_W-1:0]   in_byte,
    output logic [ACC_W-1:0]    acc_q,
    output logic                e_q,
    output logic                acc_zero,
    output logic                acc_sign,
    output logic                skip_req
);
    acc_state_t state_d, state_q;
    acc_state_t mem_nxt, rr_nxt;
    mem_op_e    mop;
    rr_cmd_t    cmd;
    skip_sel_t  ssel;
    logic       mem_any;

    always_comb begin
        mem_any = op_and | op_add | op_load | op_inbyte;
        if (op_and)         mop = MOP_AND;
        else if (op_add)    mop = MOP_ADD;
        else if (op_load)   mop = MOP_LOAD;
        else if (op_inbyte) mop = MOP_INBYTE;
        else                mop = MOP_NONE;

        cmd.clr_ac = rr_bits[RR_CLR_AC];
        cmd.clr_e  = rr_bits[RR_CLR_E];
        cmd.cmp_ac = rr_bits[RR_CMP_AC];
        cmd.cmp_e  = rr_bits[RR_CMP_E];
        cmd.ror    = rr_bits[RR_ROR];
        cmd.rol    = rr_bits[RR_ROL];
        cmd.inc    = rr_bits[RR_INC];
        ssel.pos   = rr_bits[RR_SK_POS];
        ssel.neg   = rr_bits[RR_SK_NEG];
        ssel.zer   = rr_bits[RR_SK_ZER];
        ssel.ez    = rr_bits[RR_SK_EZ];
    end

    acc_memop u_memop (
        .op      (mop),
        .cur     (state_q),
        .dr      (dr_in),
        .byte_in (in_byte),
        .nxt     (mem_nxt)
    );

    acc_rrchain u_chain (
        .cmd (cmd),
        .cur (state_q),
        .nxt (rr_nxt)
    );

    acc_skip u_skip (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (rr_en & ~mem_any),
        .sel    (ssel),
        .acc    (state_q.acc),
        .e      (state_q.e),
        .skip   (skip_req)
    );

    always_comb begin
        if (mem_any)    state_d = mem_nxt;
        else if (rr_en) state_d = rr_nxt;
        else            state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign acc_q    = state_q.acc;
    assign e_q      = state_q.e;
    assign acc_zero = (state_q.acc == '0);
    assign acc_sign = state_q.acc[ACC_W-1];

    logic rr_only;
    assign rr_only = rr_en && !mem_any && ($countones(rr_bits) == 1);

    // R2
    a_r2_and_keeps_e: assert property (@(posedge clk) disable iff (!rst_n)
        (op_and) |=> (acc_q == ($past(acc_q) & $past(dr_in))) && (e_q == $past(e_q)));
    // R3
    a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_add && !op_and) |=> ({e_q, acc_q} == {1'b0, $past(acc_q)} + {1'b0, $past(dr_in)}));
    // R4
    a_r4_byte_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inbyte && !op_and && !op_add && !op_load) |=>
            (acc_q[ACC_W-1:BYTE_W] == $past(acc_q[ACC_W-1:BYTE_W])) && $stable(e_q));
    // R5
    a_r5_clear_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_only && rr_bits[RR_CLR_AC]) |=> (acc_q == '0));
    // R7
    a_r7_ror_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_only && rr_bits[RR_ROR]) |=>
            (acc_q == {$past(e_q), $past(acc_q[ACC_W-1:1])}) && (e_q == $past(acc_q[0])));
    // R8
    a_r8_rol_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_only && rr_bits[RR_ROL]) |=>
            (acc_q == {$past(acc_q[ACC_W-2:0]), $past(e_q)}) && (e_q == $past(acc_q[ACC_W-1])));
    // R9
    a_r9_inc_keeps_e: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_only && rr_bits[RR_INC]) |=>
            (acc_q == $past(acc_q) + 1'b1) && (e_q == $past(e_q)));
    // R12
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_any && !rr_en) |=> ($stable(acc_q) && $stable(e_q)));
endmodule

// File: tb/test_acc_unit.sv
`timescale 1ns/1ps
module test_acc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_and, op_add, op_load, op_inbyte, rr_en;
    logic [11:1] rr_bits;
    logic [15:0] dr_in;
    logic [7:0]  in_byte;
    logic [15:0] acc_q;
    logic        e_q, acc_zero, acc_sign, skip_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_unit i_acc_unit (
        .clk(clk), .rst_n(rst_n),
        .op_and(op_and), .op_add(op_add), .op_load(op_load), .op_inbyte(op_inbyte),
        .rr_en(rr_en), .rr_bits(rr_bits), .dr_in(dr_in), .in_byte(in_byte),
        .acc_q(acc_q), .e_q(e_q), .acc_zero(acc_zero), .acc_sign(acc_sign),
        .skip_req(skip_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_and = 0; op_add = 0; op_load = 0; op_inbyte = 0;
        rr_en = 0; rr_bits = '0; dr_in = '0; in_byte = '0;
    endtask

    // one clocked operation; outputs sampled 1 ns after the edge
    task automatic step(input logic a, input logic ad, input logic ld, input logic ib,
                        input logic en, input logic [15:0] code,
                        input logic [15:0] dr, input logic [7:0] b);
        @(negedge clk);
        op_and = a; op_add = ad; op_load = ld; op_inbyte = ib;
        rr_en = en; rr_bits = code[11:1]; dr_in = dr; in_byte = b;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic rr(input logic [15:0] code);
        step(0, 0, 0, 0, 1, code, 16'h0, 8'h0);
    endtask

    task automatic set_state(input logic [15:0] a, input logic e);
        rr(16'h7400);
        if (e) rr(16'h7100);
        step(0, 0, 1, 0, 0, 16'h0, a, 8'h0);
    endtask

    task automatic t_reset();
        check("R1 acc", acc_q, 16'h0);
        check("R1 e", e_q, 0);
        check("R1 zero", acc_zero, 1);
        check("R1 sign", acc_sign, 0);
    endtask

    task automatic t_and();
        set_state(16'hA5F0, 1);
        step(1, 0, 0, 0, 0, 16'h0, 16'h0FF3, 8'h0);
        check("R2 and", acc_q, 16'h05F0);
        check("R2 e kept", e_q, 1);
    endtask

    task automatic t_add();
        set_state(16'hFFFF, 0);
        step(0, 1, 0, 0, 0, 16'h0, 16'h0001, 8'h0);
        check("R3 wrap", acc_q, 16'h0000);
        check("R3 carry", e_q, 1);
        check("R13 zero", acc_zero, 1);
        set_state(16'h1234, 1);
        step(0, 1, 0, 0, 0, 16'h0, 16'h4321, 8'h0);
        check("R3 sum", acc_q, 16'h5555);
        check("R3 no carry", e_q, 0);
        set_state(16'h8000, 0);
        step(0, 1, 0, 0, 0, 16'h0, 16'h8000, 8'h0);
        check("R3 sign carry", {e_q, acc_q}, 17'h10000);
    endtask

    task automatic t_load_byte();
        set_state(16'hABCD, 1);
        check("R4 load", acc_q, 16'hABCD);
        check("R13 sign", acc_sign, 1);
        step(0, 0, 0, 1, 0, 16'h0, 16'hFFFF, 8'h5A);
        check("R4 byte", acc_q, 16'hAB5A);
        check("R4 e kept", e_q, 1);
    endtask

    task automatic t_clear_cmp();
        set_state(16'h1357, 1);
        rr(16'h7800);
        check("R5 clear acc", acc_q, 16'h0);
        check("R5 e kept", e_q, 1);
        rr(16'h7400);
        check("R5 clear e", e_q, 0);
        set_state(16'h0F0F, 0);
        rr(16'h7200);
        check("R6 cmp acc", acc_q, 16'hF0F0);
        rr(16'h7100);
        check("R6 cmp e", e_q, 1);
        check("R6 acc kept", acc_q, 16'hF0F0);
    endtask

    task automatic t_rotate();
        set_state(16'h8001, 0);
        rr(16'h7080);
        check("R7 ror acc", acc_q, 16'h4000);
        check("R7 ror e", e_q, 1);
        rr(16'h7080);
        check("R7 ror e in", acc_q, 16'hA000);
        check("R7 ror e out", e_q, 0);
        set_state(16'h8001, 0);
        rr(16'h7040);
        check("R8 rol acc", acc_q, 16'h0002);
        check("R8 rol e", e_q, 1);
        set_state(16'h0000, 1);
        rr(16'h7040);
        check("R8 rol e in", {e_q, acc_q}, 17'h00001);
    endtask

    task automatic t_inc();
        set_state(16'hFFFF, 1);
        rr(16'h7020);
        check("R9 wrap", acc_q, 16'h0000);
        check("R9 e kept", e_q, 1);
        set_state(16'h7FFF, 0);
        rr(16'h7020);
        check("R9 inc", acc_q, 16'h8000);
        check("R9 e kept 0", e_q, 0);
    endtask

    task automatic skip_probe(input logic en, input logic [15:0] code, input logic exp,
                              input string req);
        @(negedge clk);
        rr_en = en; rr_bits = code[11:1];
        #1;
        check(req, skip_req, exp);
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic t_skip();
        set_state(16'h8000, 1);
        skip_probe(1, 16'h7010, 0, "R10 pos on neg");
        skip_probe(1, 16'h7008, 1, "R10 neg on neg");
        skip_probe(0, 16'h7008, 0, "R10 rr_en low");
        skip_probe(1, 16'h7002, 0, "R10 ez with e=1");
        check("R10 state kept", {e_q, acc_q}, 17'h18000);
        set_state(16'h0000, 0);
        skip_probe(1, 16'h7004, 1, "R10 zero");
        skip_probe(1, 16'h7002, 1, "R10 ez with e=0");
        skip_probe(1, 16'h7010, 1, "R10 pos on zero");
        set_state(16'h0001, 1);
        skip_probe(1, 16'h7006, 0, "R10 zero|ez none");
        skip_probe(1, 16'h7016, 1, "R10 or of tests");
    endtask

    task automatic t_priority();
        // clear, invert, rotate left, increment: 0 -> FFFF -> FFFE,e=1 -> FFFF
        set_state(16'h1234, 0);
        rr(16'h7A60);
        check("R11 acc order", acc_q, 16'hFFFF);
        check("R11 e order", e_q, 1);
        // clear E then invert E gives 1
        set_state(16'h0000, 1);
        rr(16'h7500);
        check("R11 e clr then cmp", e_q, 1);
        // right then left rotation restores the ring
        set_state(16'h8421, 1);
        rr(16'h70C0);
        check("R11 ror then rol", {e_q, acc_q}, 17'h18421);
    endtask

    task automatic t_precedence();
        set_state(16'h0000, 0);
        step(0, 0, 1, 0, 1, 16'h7800, 16'h1234, 8'h0);
        check("R12 data op wins", acc_q, 16'h1234);
        step(0, 0, 0, 0, 0, 16'h0, 16'hFFFF, 8'hFF);
        step(0, 0, 0, 0, 0, 16'h0, 16'h0, 8'h0);
        check("R12 hold acc", acc_q, 16'h1234);
        check("R12 hold e", e_q, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
        t_reset();
        t_and();
        t_add();
        t_load_byte();
        t_clear_cmp();
        t_rotate();
        t_inc();
        t_skip();
        t_priority();
        t_precedence();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule